// File: doc/BRIEF.md
# Processor Debug Halt Entry Controller

This block decides when a processor core stops running and enters a halted debug state. It also drives the core-side controls for as long as that state lasts. Halt causes come in two classes.

- **Software events.** These are vector catch, breakpoint match, watchpoint match and a breakpoint instruction. They halt the core only when halting mode is selected in the debug control field.
- **Hardware requests.** These are an external debug request pin and a halt command decoded from the JTAG TAP. They need only the debug enable pin and ignore the mode field, so a debugger can stop the core straight after reset. A TAP halt command waits until the TAP controller passes through Run-Test/Idle.

On entry the block does three things:
- It sets a core-halted status bit.
- It records a method-of-entry code.
- It holds the program counter, masks interrupts and switches instruction fetch to the instruction transfer register.

A restart command ends the halted state. A software event that arrives while halting mode is not selected produces a one-cycle debug-exception pulse instead of a halt.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While reset is asserted, and in the first sampled cycle after reset when no request is held, in_debug, core_halted, pc_hold, irq_mask, itr_select and dbg_exc are 0 and entry_code is 0.
- R2: When dbg_perm is 1, mode_field[0] (bit 14 of the control register) is 1 and any software event is high, in_debug and core_halted are 1 after the next clock edge. This holds whatever the value of mode_field[1].
- R3: When dbg_perm is 1 and mode_field[0] is 0, a software event in a cycle with no hardware halt produces dbg_exc high for exactly the following cycle, and no halt.
- R4: When dbg_en and dbg_perm are 1, ext_req halts the core after the next edge, whatever the value of mode_field.
- R5: A TAP halt command takes effect only in a cycle where tap_in_rti is 1. A command seen while tap_in_rti is 0 stays pending until the next cycle with tap_in_rti at 1. A pending command is consumed in that cycle, and it halts the core only if dbg_en and dbg_perm are 1.
- R6: On entry, entry_code records the cause: 0 TAP halt, 1 breakpoint, 2 watchpoint, 3 breakpoint instruction, 4 external request, 5 vector catch. When several qualified causes occur together, the lowest code is recorded.
- R7: While in_debug is 1, pc_hold, irq_mask and itr_select are 1, and new causes do not change entry_code.
- R8: restart while in_debug is 1 clears in_debug, core_halted, pc_hold, irq_mask and itr_select after the next edge. restart while running has no effect.
- R9: An ext_req held through reset, with dbg_en and dbg_perm at 1, enters debug state at the first clock edge after reset is released.
- R10: With dbg_perm at 0, no input pattern enters debug state or produces dbg_exc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dbg_en | input | 1 | Debug enable pin |
| dbg_perm | input | 1 | Debug permitted in the current core state |
| mode_field | input | 2 | Control register bits [15:14]; bit 0 selects halting mode |
| ev_vcatch | input | 1 | Vector catch event |
| ev_bkpt | input | 1 | Breakpoint match |
| ev_wpt | input | 1 | Watchpoint match |
| ev_bkpt_insn | input | 1 | Breakpoint instruction executed |
| ext_req | input | 1 | External debug request |
| tap_halt_cmd | input | 1 | Halt command decoded from the TAP |
| tap_in_rti | input | 1 | TAP controller is in Run-Test/Idle |
| restart | input | 1 | Restart command, leaves debug state |
| in_debug | output | 1 | Core is in debug state |
| core_halted | output | 1 | Sticky core-halted status bit |
| entry_code | output | 3 | Method-of-entry code |
| pc_hold | output | 1 | Hold the program counter |
| irq_mask | output | 1 | Ignore interrupts |
| itr_select | output | 1 | Fetch instructions from the instruction transfer register |
| dbg_exc | output | 1 | One-cycle debug-exception pulse |

## Verification
The main sweep tries every subset of the six causes against every mode_field value, both dbg_en values and both dbg_perm values. This separates the software class, which is gated by mode_field[0], from the hardware class, which is gated by dbg_en. It also shows that mode_field[1] has no effect, and it checks the lowest-code priority for every combination of simultaneous causes.

Directed sequences cover four further cases:
- A TAP command that waits for Run-Test/Idle.
- A pending command that is dropped when debug is disabled.
- Causes that arrive while the core is already halted.
- A restart issued while the core is running.

A further directed sequence holds an external request through reset.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int NUM_CAUSES = 6;
  localparam int CODE_W     = $clog2(NUM_CAUSES);

  // Cause index equals entry code; lower index has priority.
  typedef enum logic [CODE_W-1:0] {
    CODE_TAP    = 3'd0,
    CODE_BKPT   = 3'd1,
    CODE_WPT    = 3'd2,
    CODE_BINSN  = 3'd3,
    CODE_EXTREQ = 3'd4,
    CODE_VCATCH = 3'd5
  } entry_code_e;
endpackage

// File: rtl/dbg_tap_halt_gate.sv
module dbg_tap_halt_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic rti_i,
  output logic req_o
);
  logic pend_q, pend_d;

  always_comb begin
    req_o  = (cmd_i | pend_q) & rti_i;
    pend_d = pend_q;
    if (rti_i)      pend_d = 1'b0;
    else if (cmd_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !rti_i |=> pend_q);
endmodule

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb #(
  parameter int N = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dbg_halt_state.sv
module dbg_halt_state #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_i,
  input  logic [CW-1:0] code_i,
  input  logic          sw_exc_i,
  input  logic          restart_i,
  output logic          in_debug_o,
  output logic          halted_o,
  output logic [CW-1:0] code_o,
  output logic          exc_o
);
  logic          dbg_q, dbg_d;
  logic          halted_q, halted_d;
  logic [CW-1:0] code_q, code_d;
  logic          exc_q, exc_d;
  logic          code_en;

  always_comb begin
    code_en  = !dbg_q && enter_i;
    dbg_d    = dbg_q ? !restart_i : enter_i;
    halted_d = halted_q;
    if (code_en)                     halted_d = 1'b1;
    else if (dbg_q && restart_i)     halted_d = 1'b0;
    code_d   = code_en ? code_i : code_q;
    exc_d    = !dbg_q && !enter_i && sw_exc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q    <= 1'b0;
      halted_q <= 1'b0;
      code_q   <= '0;
      exc_q    <= 1'b0;
    end else begin
      dbg_q    <= dbg_d;
      halted_q <= halted_d;
      exc_q    <= exc_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign in_debug_o = dbg_q;
  assign halted_o   = halted_q;
  assign code_o     = code_q;
  assign exc_o      = exc_q;

  // R8
  restart_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q && restart_i |=> !halted_q && !dbg_q);
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q && !restart_i |=> dbg_q && $stable(code_q));
  // R3
  exc_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_q |-> !dbg_q);
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              dbg_perm,
  input  logic [1:0]        mode_field,
  input  logic              ev_vcatch,
  input  logic              ev_bkpt,
  input  logic              ev_wpt,
  input  logic              ev_bkpt_insn,
  input  logic              ext_req,
  input  logic              tap_halt_cmd,
  input  logic              tap_in_rti,
  input  logic              restart,
  output logic              in_debug,
  output logic              core_halted,
  output logic [CODE_W-1:0] entry_code,
  output logic              pc_hold,
  output logic              irq_mask,
  output logic              itr_select
  ,output logic             dbg_exc
);
  logic                  tap_req;
  logic                  hw_ok, sw_ok, sw_any;
  logic [NUM_CAUSES-1:0] cause;
  logic                  enter;
  logic [CODE_W-1:0]     enter_code;

  dbg_tap_halt_gate tap_gate_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (tap_halt_cmd),
    .rti_i (tap_in_rti),
    .req_o (tap_req)
  );

  always_comb begin
    hw_ok  = dbg_en & dbg_perm;
    sw_ok  = mode_field[0] & dbg_perm;
    sw_any = ev_vcatch | ev_bkpt | ev_wpt | ev_bkpt_insn;
    cause  = '0;
    cause[CODE_TAP]    = tap_req      & hw_ok;
    cause[CODE_BKPT]   = ev_bkpt      & sw_ok;
    cause[CODE_WPT]    = ev_wpt       & sw_ok;
    cause[CODE_BINSN]  = ev_bkpt_insn & sw_ok;
    cause[CODE_EXTREQ] = ext_req      & hw_ok;
    cause[CODE_VCATCH] = ev_vcatch    & sw_ok;
  end

  dbg_cause_arb #(.N(NUM_CAUSES)) arb_i (
    .req_i (cause),
    .any_o (enter),
    .idx_o (enter_code)
  );

  dbg_halt_state #(.CW(CODE_W)) state_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_i    (enter),
    .code_i     (enter_code),
    .sw_exc_i   (sw_any & dbg_perm & ~mode_field[0]),
    .restart_i  (restart),
    .in_debug_o (in_debug),
    .halted_o   (core_halted),
    .code_o     (entry_code),
    .exc_o      (dbg_exc)
  );

  assign pc_hold    = in_debug;
  assign irq_mask   = in_debug;
  assign itr_select = in_debug;

  // R4
  ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug && ext_req && dbg_en && dbg_perm |=> in_debug && core_halted);
  // R10
  no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_debug && !dbg_perm |=> !in_debug && !dbg_exc);
endmodule

// File: tb/dbg_halt_ctrl_tb_top.sv
module dbg_halt_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic dbg_en, dbg_perm, ev_vcatch, ev_bkpt, ev_wpt, ev_bkpt_insn;
  logic ext_req, tap_halt_cmd, tap_in_rti, restart;
  logic [1:0] mode_field;
  logic in_debug, core_halted, pc_hold, irq_mask, itr_select, dbg_exc;
  logic [2:0] entry_code;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbg_halt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .dbg_perm(dbg_perm),
    .mode_field(mode_field), .ev_vcatch(ev_vcatch), .ev_bkpt(ev_bkpt),
    .ev_wpt(ev_wpt), .ev_bkpt_insn(ev_bkpt_insn), .ext_req(ext_req),
    .tap_halt_cmd(tap_halt_cmd), .tap_in_rti(tap_in_rti), .restart(restart),
    .in_debug(in_debug), .core_halted(core_halted), .entry_code(entry_code),
    .pc_hold(pc_hold), .irq_mask(irq_mask), .itr_select(itr_select),
    .dbg_exc(dbg_exc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_vcatch = 0; ev_bkpt = 0; ev_wpt = 0; ev_bkpt_insn = 0;
    ext_req = 0; tap_halt_cmd = 0; tap_in_rti = 0; restart = 0;
  endtask

  // One edge, then sample at the following falling edge.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_restart();
    restart = 1; cyc(); restart = 0;
  endtask

  task automatic chk_halted(input string req, input int exp);
    chk({req, " in_debug"}, in_debug, exp);
    chk({req, " core_halted"}, core_halted, exp);
    chk({req, " pc_hold/irq_mask/itr_select"}, {pc_hold, irq_mask, itr_select},
        exp ? 7 : 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    dbg_en = 1; dbg_perm = 1; mode_field = 2'b00;
    rst_n = 0;
    // R9: external request held through reset
    ext_req = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_halted("R1", 0);
    chk("R1 dbg_exc", dbg_exc, 0);
    chk("R1 entry_code", entry_code, 0);
    rst_n = 1;
    cyc();
    chk_halted("R9", 1);
    chk("R9 entry_code", entry_code, 4);
    ext_req = 0;
    do_restart();
    chk_halted("R8 restart", 0);

    // R1: clean reset with nothing held
    rst_n = 0; @(negedge clk); rst_n = 1; cyc();
    chk_halted("R1 post-reset", 0);
    chk("R1 post-reset dbg_exc", dbg_exc, 0);

    // Exhaustive sweep: causes x mode_field x dbg_en x dbg_perm
    for (int c = 0; c < 64; c++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int p = 0; p < 2; p++) begin
            bit jt, bk, wp, bi, ex, vc, hw, sw, halt, exc;
            int code;
            jt = c[0]; bk = c[1]; wp = c[2]; bi = c[3]; ex = c[4]; vc = c[5];
            hw = e && p;
            sw = m[0] && p;
            code = 7;
            if (vc && sw) code = 5;
            if (ex && hw) code = 4;
            if (bi && sw) code = 3;
            if (wp && sw) code = 2;
            if (bk && sw) code = 1;
            if (jt && hw) code = 0;
            halt = (code != 7);
            exc = !halt && p && !m[0] && (vc || bk || wp || bi);
            dbg_en = e[0]; dbg_perm = p[0]; mode_field = m[1:0];
            ev_vcatch = vc; ev_bkpt = bk; ev_wpt = wp; ev_bkpt_insn = bi;
            ext_req = ex; tap_halt_cmd = jt; tap_in_rti = jt;
            cyc();
            idle_inputs();
            if (!p) chk("R10 no entry without permission", in_debug, 0);
            else if (jt || ex) chk("R4/R5 hardware entry", in_debug, halt);
            else chk("R2 software entry", in_debug, halt);
            chk("R7 controls follow debug state", {pc_hold, irq_mask, itr_select},
                halt ? 7 : 0);
            if (halt) chk("R6 entry code priority", entry_code, code);
            chk("R3 exception pulse", dbg_exc, exc);
            cyc();
            chk("R3 pulse lasts one cycle", dbg_exc, 0);
            if (halt) begin
              do_restart();
              chk_halted("R8 restart", 0);
            end
          end
        end
      end
    end

    dbg_en = 1; dbg_perm = 1; mode_field = 2'b01;
    // R5: TAP command waits for Run-Test/Idle
    tap_halt_cmd = 1; cyc(); tap_halt_cmd = 0;
    repeat (3) cyc();
    chk("R5 no halt before RTI", in_debug, 0);
    tap_in_rti = 1; cyc(); tap_in_rti = 0;
    chk("R5 halt at RTI", in_debug, 1);
    chk("R5 TAP code", entry_code, 0);
    // R7: causes while halted do not alter the code
    ev_wpt = 1; ext_req = 1; cyc(); idle_inputs();
    chk("R7 code held while halted", entry_code, 0);
    chk("R7 still halted", in_debug, 1);
    do_restart();
    chk_halted("R8 exit", 0);

    // R5: pending command dropped when debug is disabled at RTI
    dbg_en = 0;
    tap_halt_cmd = 1; cyc(); tap_halt_cmd = 0;
    tap_in_rti = 1; cyc(); tap_in_rti = 0;
    chk("R5 disabled at RTI", in_debug, 0);
    dbg_en = 1;
    tap_in_rti = 1; cyc(); tap_in_rti = 0;
    chk("R5 pending consumed", in_debug, 0);

    // R8: restart while running has no effect
    do_restart();
    chk_halted("R8 restart while running", 0);
    // R2: halting mode with bit 15 also set
    mode_field = 2'b11; ev_bkpt_insn = 1; cyc(); idle_inputs();
    chk("R2 breakpoint instruction halt", in_debug, 1);
    chk("R6 breakpoint instruction code", entry_code, 3);
    do_restart();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule